// File: doc/BRIEF.md
# Clock Source Startup Sequencer

This block brings up the core clock of a peripheral. A start pulse launches a bring-up sequence whose path is picked by a 2-bit mode input. In the automatic and PLL-only modes the sequencer first turns on the on-chip PLL while the clock gate stays stopped. It waits a settle interval and then checks the PLL lock input at a fixed polling interval inside a bounded window. Once enough lock observations have been collected, the PLL becomes the clock source. In the external modes the oscillator path is configured directly, with no check that the oscillator is running.

If the PLL never qualifies, the PLL-only mode ends in a fault with the gate still stopped. The automatic mode instead falls back to the external crystal path. The clock gate opens only one cycle after the source configuration has been written. A stop request performs an orderly shutdown: the gate closes first, and the source enables are cleared one cycle later. All intervals are counted in pulses of a reference tick input, so the real-time values become parameters.

Top module: `clk_bringup_seq`

## Requirements
- R1: After reset, all enables, `gate_en`, `done` and `err` are low, and `src` reads 00 (no source).
- R2: A start in mode 00 (auto) or 01 (PLL only) raises `pll_en` one cycle later. `gate_en` and `done` stay low while lock is being qualified.
- R3: The first lock observation is taken on the SETTLE_TICKS-th tick after the start. Later observations follow every POLL_TICKS ticks. No observation is taken after tick WINDOW_TICKS.
- R4: The PLL is accepted when LOCK_HITS observations have seen lock high, whether or not they are consecutive. Polling stops at that observation. `src` then reads 01 and `pll_en` stays high.
- R5: In mode 01, if the window ends without enough lock observations, `err` rises, `pll_en` falls, and `gate_en` and `done` stay low.
- R6: In mode 00, the same failure switches to the crystal path: `pll_en` low, `ext_en` and `xtal_sel` high, and `src` = 11. Bring-up then completes normally.
- R7: Mode 10 sets `ext_en` with `xtal_sel` low and `src` = 10. Mode 11 sets `ext_en` and `xtal_sel` with `src` = 11. Neither mode waits on any tick or on lock.
- R8: `gate_en` rises exactly one cycle after the source enables and `src` are written. `done` rises together with it.
- R9: `done` stays high until a shutdown. A start pulse is ignored while a bring-up is in progress or the clock is running.
- R10: After a stop request while running, `gate_en` falls first with the enables unchanged. On the following cycle `pll_en`, `ext_en`, `xtal_sel`, `done` and `src` all clear.
- R11: A stop request while `err` is high clears `err` and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Reference time-base pulse, one cycle wide |
| start | input | 1 | Begin bring-up (pulse) |
| stop | input | 1 | Begin orderly shutdown (pulse) |
| mode | input | 2 | 00 auto, 01 PLL only, 10 external clock, 11 external crystal |
| pll_lock | input | 1 | Lock indication from the PLL |
| pll_en | output | 1 | PLL enable |
| ext_en | output | 1 | External oscillator path enable |
| xtal_sel | output | 1 | Selects the crystal variant of the external path |
| gate_en | output | 1 | Clock gate open (core clock running) |
| done | output | 1 | Bring-up complete |
| err | output | 1 | PLL failed to qualify in PLL-only mode |
| src | output | 2 | Chosen source: 00 none, 01 PLL, 10 external, 11 crystal |

## Verification
Every cycle, the assertions check the following:
- the gate never opens without a source configured one cycle before;
- a fault keeps the gate closed and the PLL off;
- the crystal select never appears without the external enable;
- shutdown closes the gate before any enable changes;
- the lock qualifier never overruns its hit count or its sample window.

Only the bench scenarios can show the rest. These are the tick at which the decision is made for a given lock pattern, the early stop at the qualifying observation, the choice between fallback and fault for each mode, and the fact that a start pulse during bring-up leaves the result unchanged.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

   typedef enum logic [1:0] {
      MODE_AUTO = 2'b00,
      MODE_PLL  = 2'b01,
      MODE_EXT  = 2'b10,
      MODE_XTAL = 2'b11
   } clk_mode_e;

   typedef enum logic [1:0] {
      SRC_NONE = 2'b00,
      SRC_PLL  = 2'b01,
      SRC_EXT  = 2'b10,
      SRC_XTAL = 2'b11
   } clk_src_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_GATE,
      ST_RUN,
      ST_SHUT,
      ST_FAULT
   } seq_state_e;

endpackage

// File: rtl/clkseq_tick_timer.sv
module clkseq_tick_timer #(
   parameter int FIRST_TICKS = 500,
   parameter int NEXT_TICKS  = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   input  logic tick,
   output logic expire
);
   localparam int MAXV  = (FIRST_TICKS > NEXT_TICKS) ? FIRST_TICKS : NEXT_TICKS;
   localparam int CNT_W = $clog2(MAXV + 1);
   localparam logic [CNT_W-1:0] FIRST_LD = CNT_W'(FIRST_TICKS - 1);
   localparam logic [CNT_W-1:0] NEXT_LD  = CNT_W'(NEXT_TICKS - 1);

   generate
      if (FIRST_TICKS < 1) begin : g_bad_first
         $error("clkseq_tick_timer: FIRST_TICKS must be at least 1");
      end
      if (NEXT_TICKS < 1) begin : g_bad_next
         $error("clkseq_tick_timer: NEXT_TICKS must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   assign expire = run && tick && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= FIRST_LD;
      end else if (run && tick) begin
         if (cnt == '0) cnt <= NEXT_LD;
         else           cnt <= cnt - 1'b1;
      end
   end

   // R3: the count never leaves the range of the longer interval
   p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(MAXV - 1));

endmodule

// File: rtl/clkseq_lock_qual.sv
module clkseq_lock_qual #(
   parameter int HITS    = 3,
   parameter int SAMPLES = 191
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic sample,
   input  logic lock,
   output logic locked,
   output logic failed
);
   localparam int HW = $clog2(HITS + 1);
   localparam int SW = $clog2(SAMPLES + 1);

   generate
      if (HITS < 1) begin : g_bad_hits
         $error("clkseq_lock_qual: HITS must be at least 1");
      end
      if (HITS > SAMPLES) begin : g_bad_window
         $error("clkseq_lock_qual: window holds fewer samples than HITS");
      end
   endgenerate

   logic [HW-1:0] hit_cnt, hit_nxt;
   logic [SW-1:0] smp_cnt, smp_nxt;
   logic          take;

   assign take    = sample && !locked && !failed;
   assign hit_nxt = hit_cnt + HW'(lock);
   assign smp_nxt = smp_cnt + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         hit_cnt <= '0;
         smp_cnt <= '0;
         locked  <= 1'b0;
         failed  <= 1'b0;
      end else if (take) begin
         hit_cnt <= hit_nxt;
         smp_cnt <= smp_nxt;
         if (hit_nxt == HW'(HITS))         locked <= 1'b1;
         else if (smp_nxt == SW'(SAMPLES)) failed <= 1'b1;
      end
   end

   p_hit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_cnt <= HW'(HITS));

   p_outcome_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(locked && failed));

   p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      smp_cnt <= SW'(SAMPLES));

   p_stop_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && sample && !clear) |=> ($stable(hit_cnt) && $stable(smp_cnt)));

endmodule

// File: rtl/clk_bringup_seq.sv
module clk_bringup_seq
   import clkseq_pkg::*;
#(
   parameter int SETTLE_TICKS = 500,
   parameter int POLL_TICKS   = 50,
   parameter int WINDOW_TICKS = 10000,
   parameter int LOCK_HITS    = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       start,
   input  logic       stop,
   input  logic [1:0] mode,
   input  logic       pll_lock,
   output logic       pll_en,
   output logic       ext_en,
   output logic       xtal_sel,
   output logic       gate_en,
   output logic       done,
   output logic       err,
   output logic [1:0] src
);
   localparam int SAMPLES = (WINDOW_TICKS - SETTLE_TICKS) / POLL_TICKS + 1;

   generate
      if (WINDOW_TICKS < SETTLE_TICKS) begin : g_bad_window
         $error("clk_bringup_seq: WINDOW_TICKS shorter than SETTLE_TICKS");
      end
      if (POLL_TICKS < 2) begin : g_bad_poll
         $error("clk_bringup_seq: POLL_TICKS must be at least 2");
      end
   endgenerate

   seq_state_e state;
   clk_mode_e  mode_q;
   clk_src_e   src_q;
   logic       start_ok, expire, q_locked, q_failed;

   assign start_ok = start && (state == ST_IDLE || state == ST_FAULT) && !stop;
   assign src      = src_q;

   clkseq_tick_timer #(
      .FIRST_TICKS (SETTLE_TICKS),
      .NEXT_TICKS  (POLL_TICKS)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start_ok),
      .run     (state == ST_WAIT),
      .tick    (tick),
      .expire  (expire)
   );

   clkseq_lock_qual #(
      .HITS    (LOCK_HITS),
      .SAMPLES (SAMPLES)
   ) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start_ok),
      .sample (expire),
      .lock   (pll_lock),
      .locked (q_locked),
      .failed (q_failed)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         mode_q   <= MODE_AUTO;
         src_q    <= SRC_NONE;
         pll_en   <= 1'b0;
         ext_en   <= 1'b0;
         xtal_sel <= 1'b0;
         gate_en  <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
      end else begin
         case (state)
            ST_IDLE, ST_FAULT: begin
               if (stop && state == ST_FAULT) begin
                  err   <= 1'b0;
                  state <= ST_IDLE;
               end else if (start_ok) begin
                  err    <= 1'b0;
                  mode_q <= clk_mode_e'(mode);
                  if (!mode[1]) begin
                     pll_en <= 1'b1;
                     state  <= ST_WAIT;
                  end else begin
                     ext_en   <= 1'b1;
                     xtal_sel <= mode[0];
                     src_q    <= mode[0] ? SRC_XTAL : SRC_EXT;
                     state    <= ST_GATE;
                  end
               end
            end
            ST_WAIT: begin
               if (stop) begin
                  state <= ST_SHUT;
               end else if (q_locked) begin
                  src_q <= SRC_PLL;
                  state <= ST_GATE;
               end else if (q_failed) begin
                  pll_en <= 1'b0;
                  if (mode_q == MODE_PLL) begin
                     err   <= 1'b1;
                     state <= ST_FAULT;
                  end else begin
                     ext_en   <= 1'b1;
                     xtal_sel <= 1'b1;
                     src_q    <= SRC_XTAL;
                     state    <= ST_GATE;
                  end
               end
            end
            ST_GATE: begin
               if (stop) begin
                  state <= ST_SHUT;
               end else begin
                  gate_en <= 1'b1;
                  done    <= 1'b1;
                  state   <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (stop) begin
                  gate_en <= 1'b0;
                  state   <= ST_SHUT;
               end
            end
            ST_SHUT: begin
               pll_en   <= 1'b0;
               ext_en   <= 1'b0;
               xtal_sel <= 1'b0;
               src_q    <= SRC_NONE;
               done     <= 1'b0;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_wait_gate_shut_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> (pll_en && !gate_en && !done));

   p_fault_safe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!gate_en && !pll_en && !done));

   p_xtal_needs_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xtal_sel |-> ext_en);

   p_gate_after_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_en) |-> (($past(src_q) != SRC_NONE) && $past(pll_en || ext_en)));

   p_gate_implies_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en |-> done);

   p_stop_gate_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_en) |-> ($stable(pll_en) && $stable(ext_en) && done));

   p_sources_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_en) |=> (!pll_en && !ext_en && !xtal_sel && !done));

   p_fault_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (err && stop) |=> !err);

endmodule

// File: tb/clk_bringup_seq_tb.sv
module clk_bringup_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 4;
   localparam int POLL       = 2;
   localparam int WINDOW     = 12;
   localparam int HITS       = 3;
   localparam int NSMP       = (WINDOW - SETTLE) / POLL + 1;

   typedef struct packed {
      logic [1:0] mode;
      logic [4:0] pat;     // bit k = lock level at observation k+1
      logic [1:0] esrc;
      logic       eerr;
      logic       epll;
      logic       eext;
      logic       exsel;
      logic [7:0] eticks;
      logic       cticks;
   } vec_t;

   localparam vec_t VEC [0:7] = '{
      '{2'd0, 5'b00111, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd8,  1'b1},
      '{2'd1, 5'b10101, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd12, 1'b1},
      '{2'd1, 5'b01011, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd10, 1'b1},
      '{2'd1, 5'b00011, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd12, 1'b1},
      '{2'd0, 5'b01001, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'd12, 1'b1},
      '{2'd2, 5'b11111, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0,  1'b0},
      '{2'd3, 5'b11111, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'd0,  1'b0},
      '{2'd0, 5'b11100, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd12, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       start = 1'b0;
   logic       stop = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       pll_lock;
   logic       pll_en, ext_en, xtal_sel, gate_en, done, err;
   logic [1:0] src;

   int   n_tests = 0;
   int   n_fail  = 0;
   int   cyc     = 0;
   int   tcnt    = 0;
   logic tc_clr  = 1'b0;
   logic [4:0] cur_pat = '0;
   logic [1:0] div = '0;

   clk_bringup_seq #(
      .SETTLE_TICKS (SETTLE),
      .POLL_TICKS   (POLL),
      .WINDOW_TICKS (WINDOW),
      .LOCK_HITS    (HITS)
   ) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .start    (start),
      .stop     (stop),
      .mode     (mode),
      .pll_lock (pll_lock),
      .pll_en   (pll_en),
      .ext_en   (ext_en),
      .xtal_sel (xtal_sel),
      .gate_en  (gate_en),
      .done     (done),
      .err      (err),
      .src      (src)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // one tick every fourth cycle
   always @(negedge clk) begin
      div  <= div + 2'd1;
      tick <= (div == 2'd3);
   end

   // ticks counted since the last counted start pulse
   always @(posedge clk) begin
      if (start && tc_clr) tcnt <= 0;
      else if (tick)       tcnt <= tcnt + 1;
   end

   // lock level presented for the upcoming observation
   always_comb begin
      int nxt, k;
      nxt = tcnt + 1;
      pll_lock = 1'b0;
      if (nxt >= SETTLE) begin
         k = (nxt - SETTLE) / POLL;
         if (k < NSMP) pll_lock = cur_pat[k];
      end
   end

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
         summary();
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_tests = n_tests + 1;
      if (act != exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_start(input logic [1:0] m, input logic clr);
      @(negedge clk);
      mode = m; start = 1'b1; tc_clr = clr;
      @(negedge clk);
      start = 1'b0; tc_clr = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
   endtask

   task automatic wait_outcome(input string req, output int ticks);
      bit seen = 1'b0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (done || err) begin seen = 1'b1; break; end
      end
      check(req, int'(seen), 1);
      ticks = tcnt;
   endtask

   task automatic check_idle(input string req);
      check(req, {pll_en, ext_en, xtal_sel, gate_en, done, err}, 0);
      check(req, int'(src), 0);
   endtask

   initial begin
      int t;
      // R1: reset state
      repeat (4) @(negedge clk);
      check_idle("R1 in reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_idle("R1 after reset");

      // table walk: R3 R4 R5 R6 R7
      for (int v = 0; v < 8; v++) begin
         cur_pat = VEC[v].pat;
         pulse_start(VEC[v].mode, 1'b1);
         wait_outcome("R3 outcome reached", t);
         if (VEC[v].cticks) check("R3 R4 decision tick", t, int'(VEC[v].eticks));
         check("R4 R6 R7 src", int'(src), int'(VEC[v].esrc));
         check("R5 err", int'(err), int'(VEC[v].eerr));
         check("R5 R6 pll_en", int'(pll_en), int'(VEC[v].epll));
         check("R6 R7 ext_en", int'(ext_en), int'(VEC[v].eext));
         check("R6 R7 xtal_sel", int'(xtal_sel), int'(VEC[v].exsel));
         check("R5 R8 gate_en", int'(gate_en), int'(!VEC[v].eerr));
         pulse_stop();
         repeat (2) @(negedge clk);
         check_idle("R10 R11 back to idle");
      end

      // R2: PLL on, gate closed during qualification
      cur_pat = 5'b00111;
      pulse_start(2'd1, 1'b1);
      check("R2 pll_en raised", int'(pll_en), 1);
      repeat (3) @(negedge clk);
      check("R2 gate closed in wait", int'(gate_en), 0);
      check("R2 done low in wait", int'(done), 0);

      // R9: start while busy ignored
      pulse_start(2'd2, 1'b0);
      check("R9 busy start ignored ext_en", int'(ext_en), 0);
      wait_outcome("R9 outcome", t);
      check("R9 decision unchanged", t, 8);
      check("R9 src PLL", int'(src), 1);

      // R10: orderly shutdown
      pulse_stop();
      check("R10 gate closed first", int'(gate_en), 0);
      check("R10 pll still on", int'(pll_en), 1);
      check("R10 done still high", int'(done), 1);
      @(negedge clk);
      check("R10 pll cleared", int'(pll_en), 0);
      check("R10 done cleared", int'(done), 0);
      check("R10 src cleared", int'(src), 0);

      // R8: gate follows configuration by one cycle
      pulse_start(2'd3, 1'b1);
      check("R8 ext_en written", int'(ext_en), 1);
      check("R8 xtal_sel written", int'(xtal_sel), 1);
      check("R8 gate not yet", int'(gate_en), 0);
      @(negedge clk);
      check("R8 gate opened", int'(gate_en), 1);
      check("R8 done with gate", int'(done), 1);

      // R9: done held while running, start ignored
      repeat (50) @(negedge clk);
      pulse_start(2'd2, 1'b0);
      @(negedge clk);
      check("R9 done held", int'(done), 1);
      check("R9 src unchanged", int'(src), 3);
      check("R9 xtal_sel unchanged", int'(xtal_sel), 1);
      pulse_stop();
      repeat (2) @(negedge clk);
      check_idle("R10 idle after run");

      // R5 R11: fault, then stop clears it
      cur_pat = 5'b00000;
      pulse_start(2'd1, 1'b1);
      wait_outcome("R5 fault", t);
      check("R5 fault err", int'(err), 1);
      repeat (10) @(negedge clk);
      check("R5 gate stays closed", int'(gate_en), 0);
      pulse_stop();
      check("R11 err cleared", int'(err), 0);
      check_idle("R11 idle");

      summary();
      $finish;
   end
endmodule